// File: doc/BRIEF.md
# PLL Bypass and Relock Controller

This block drives the clock-mode register of one PLL in two steps. On a bypass request it captures the whole clock-mode word the register holds and writes it back with the 3-bit enable field, bits [2:0], set to the low-power bypass code. It then stays busy until the PLL idle-status input falls to zero. On a relock request it writes the captured word back as it was. When the enable field of that word is the lock code, the block waits for the idle-status input to become nonzero. For any other code it finishes in the same cycle as the write.

A requester starts an operation with a one-cycle request and watches `busy` and `done`. A second request that arrives while an operation is running has no effect. The block also drives the post-divider field of the clock-select register straight to an output port.

Top module: `pll_byp_ctl`

## Requirements
- R1: After a synchronous active-low reset, `busy`, `done` and `clkmode_wr_en` are 0, and the saved mode word is 0. A relock issued straight after reset therefore writes 0 and sets `done` on the request edge.
- R2: When `byp_req` is sampled while the block is idle, `clkmode_wr_en` is high for the next cycle and `clkmode_wr_data` equals `clkmode_rd` with bits [2:0] replaced by 3'b101.
- R3: After a bypass write, `busy` stays high until `pll_idle_st` is sampled as 0. `done` is set on that same edge.
- R4: A relock write places on `clkmode_wr_data` the full `clkmode_rd` word captured at the most recent accepted bypass request.
- R5: When bits [2:0] of the restored word are 3'b111, `busy` stays high after the relock write until `pll_idle_st` is sampled as 1. `done` is set on that same edge.
- R6: When bits [2:0] of the restored word are not 3'b111, `done` is set on the relock request edge and `busy` does not rise.
- R7: `done` is high for exactly one cycle per operation.
- R8: While `busy` is high, `byp_req` and `lock_req` are ignored. No write is issued and no extra `done` is produced.
- R9: `post_div` always equals bits [7:0] of `clksel_rd`, with no shift applied.
- R10: When `byp_req` and `lock_req` are both sampled in the idle state, the bypass operation is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| byp_req | input | 1 | Request to enter bypass (one-cycle pulse) |
| lock_req | input | 1 | Request to restore the saved mode (one-cycle pulse) |
| clkmode_rd | input | 32 | Current clock-mode register value |
| clkmode_wr_en | output | 1 | Clock-mode register write strobe |
| clkmode_wr_data | output | 32 | Clock-mode register write value |
| pll_idle_st | input | 1 | PLL idle-status (0 = bypass, nonzero = locked) |
| clksel_rd | input | 32 | Current clock-select register value |
| post_div | output | 8 | Post-divider field from the clock-select register |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
Counting from the edge that samples a request, the write strobe is due one cycle after that edge. On a relock whose restored code is not the lock code, `done` is due on the request edge itself. On a waiting operation, `done` is due one edge after the status input changes. The bench's PLL model changes the status input D+2 edges after the request edge, so a waiting operation finishes at D+3. The bench drives and samples only on falling edges, counts edges from the request, and compares the count to this figure for every enable code and for delays 0 to 3. It also checks that no write appears at any other count.

// File: rtl/pll_byp_pkg.sv
// Shared constants and the sequencer state type for the PLL bypass controller.
// Assumes the mode-enable field sits in the low bits of the clock-mode word.
package pll_byp_pkg;
    localparam int          EN_W      = 3;
    localparam logic [2:0]  BYP_CODE  = 3'b101;
    localparam logic [2:0]  LOCK_CODE = 3'b111;

    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_BYP_WAIT  = 2'd1,
        ST_LOCK_WAIT = 2'd2
    } seq_state_t;
endpackage

// File: rtl/pll_mode_store.sv
// Holds the clock-mode word captured at an accepted bypass request.
// Assumes cap_en is a single-cycle strobe from the sequencer; reset clears to 0.
module pll_mode_store #(
    parameter int MODE_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_en,
    input  logic [MODE_W-1:0] cap_word,
    output logic [MODE_W-1:0] saved
);
    // Capture register for the prior mode word.
    always_ff @(posedge clk) begin
        if (!rst_n)      saved <= '0;
        else if (cap_en) saved <= cap_word;
    end
endmodule

// File: rtl/pll_seq_fsm.sv
// Sequencer: issues the bypass and relock writes and waits on PLL idle status.
// Assumes requests are sampled only in the idle state; bypass wins a tie.
module pll_seq_fsm
    import pll_byp_pkg::*;
#(
    parameter int MODE_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byp_req,
    input  logic              lock_req,
    input  logic              idle_st,
    input  logic [MODE_W-1:0] cur_mode,
    input  logic [MODE_W-1:0] saved_mode,
    output logic              cap_en,
    output logic              wr_en,
    output logic [MODE_W-1:0] wr_data,
    output logic              busy,
    output logic              done
);
    seq_state_t state;
    logic       take_byp;
    logic       take_lock;
    logic       restore_is_lock;

    // Request acceptance decode; bypass has priority over relock.
    always_comb begin
        take_byp        = (state == ST_IDLE) && byp_req;
        take_lock       = (state == ST_IDLE) && !byp_req && lock_req;
        restore_is_lock = (saved_mode[EN_W-1:0] == LOCK_CODE);
        cap_en          = take_byp;
        busy            = (state != ST_IDLE);
    end

    // State, write strobe, write data and completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            wr_en   <= 1'b0;
            wr_data <= '0;
            done    <= 1'b0;
        end else begin
            wr_en <= 1'b0;
            done  <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (take_byp) begin
                        wr_en   <= 1'b1;
                        wr_data <= {cur_mode[MODE_W-1:EN_W], BYP_CODE};
                        state   <= ST_BYP_WAIT;
                    end else if (take_lock) begin
                        wr_en   <= 1'b1;
                        wr_data <= saved_mode;
                        if (restore_is_lock) state <= ST_LOCK_WAIT;
                        else                 done  <= 1'b1;
                    end
                end
                ST_BYP_WAIT: begin
                    if (!idle_st) begin
                        state <= ST_IDLE;
                        done  <= 1'b1;
                    end
                end
                ST_LOCK_WAIT: begin
                    if (idle_st) begin
                        state <= ST_IDLE;
                        done  <= 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Bypass write carries the bypass code one cycle after acceptance.
    assert_byp_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && byp_req) |=> (wr_en && wr_data[EN_W-1:0] == BYP_CODE));
    // Busy holds while the PLL still reports lock after a bypass write.
    assert_byp_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BYP_WAIT && idle_st) |=> (busy && !done));
    // A lock-code restore keeps busy high.
    assert_lock_wait_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !byp_req && lock_req && saved_mode[EN_W-1:0] == LOCK_CODE)
        |=> (busy && !done));
    // Other restores complete on the request edge.
    assert_lock_nowait_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !byp_req && lock_req && saved_mode[EN_W-1:0] != LOCK_CODE)
        |=> (done && !busy));
    // Done is a one-cycle pulse.
    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // No write while an operation is running.
    assert_no_write_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !wr_en);
endmodule

// File: rtl/pll_div_field.sv
// Extracts the post-divider field from the clock-select register value.
// Assumes the field is DIV_W bits at DIV_LSB; purely combinational.
module pll_div_field #(
    parameter int SEL_W   = 32,
    parameter int DIV_W   = 8,
    parameter int DIV_LSB = 0
) (
    input  logic [SEL_W-1:0] clksel,
    output logic [DIV_W-1:0] div
);
    logic unused_sel_bits;

    // Field select with the configured shift.
    always_comb begin
        div             = clksel[DIV_LSB +: DIV_W];
        unused_sel_bits = ^clksel;
    end
endmodule

// File: rtl/pll_byp_ctl.sv
// Top: PLL bypass and relock controller over a register-level interface.
// Assumes clkmode_rd reflects the register contents every cycle.
module pll_byp_ctl #(
    parameter int MODE_W = 32,
    parameter int SEL_W  = 32,
    parameter int DIV_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byp_req,
    input  logic              lock_req,
    input  logic [MODE_W-1:0] clkmode_rd,
    output logic              clkmode_wr_en,
    output logic [MODE_W-1:0] clkmode_wr_data,
    input  logic              pll_idle_st,
    input  logic [SEL_W-1:0]  clksel_rd,
    output logic [DIV_W-1:0]  post_div,
    output logic              busy,
    output logic              done
);
    logic              cap_en;
    logic [MODE_W-1:0] saved_mode;

    pll_mode_store #(.MODE_W(MODE_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap_en   (cap_en),
        .cap_word (clkmode_rd),
        .saved    (saved_mode)
    );

    pll_seq_fsm #(.MODE_W(MODE_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .byp_req    (byp_req),
        .lock_req   (lock_req),
        .idle_st    (pll_idle_st),
        .cur_mode   (clkmode_rd),
        .saved_mode (saved_mode),
        .cap_en     (cap_en),
        .wr_en      (clkmode_wr_en),
        .wr_data    (clkmode_wr_data),
        .busy       (busy),
        .done       (done)
    );

    pll_div_field #(.SEL_W(SEL_W), .DIV_W(DIV_W), .DIV_LSB(0)) u_div (
        .clksel (clksel_rd),
        .div    (post_div)
    );

    // Relock writes back the word captured at the bypass request.
    assert_restore_word_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !byp_req && lock_req) |=> (clkmode_wr_en && clkmode_wr_data == $past(saved_mode)));
endmodule

// File: tb/pll_byp_ctl_tb.sv
module pll_byp_ctl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        byp_req = 1'b0;
    logic        lock_req = 1'b0;
    logic [31:0] cm_reg = '0;
    logic        wr_en;
    logic [31:0] wr_data;
    logic        idle_st = 1'b0;
    logic [31:0] clksel = '0;
    logic [7:0]  post_div;
    logic        busy;
    logic        done;

    int tests = 0;
    int fails = 0;
    int dly = 0;
    logic        sw_load = 1'b0;
    logic [31:0] sw_word = '0;
    logic        pend = 1'b0;
    int          cnt = 0;
    logic        tgt = 1'b0;

    always #10 clk = ~clk;

    pll_byp_ctl u_dut (
        .clk(clk), .rst_n(rst_n), .byp_req(byp_req), .lock_req(lock_req),
        .clkmode_rd(cm_reg), .clkmode_wr_en(wr_en), .clkmode_wr_data(wr_data),
        .pll_idle_st(idle_st), .clksel_rd(clksel), .post_div(post_div),
        .busy(busy), .done(done));

    // PLL model: status follows the written enable code after dly+1 edges.
    always @(posedge clk) begin
        if (sw_load) begin
            cm_reg  <= sw_word;
            idle_st <= (sw_word[2:0] == 3'b111);
            pend    <= 1'b0;
        end else if (wr_en) begin
            cm_reg <= wr_data;
            tgt    <= (wr_data[2:0] == 3'b111);
            cnt    <= dly;
            pend   <= 1'b1;
        end else if (pend) begin
            if (cnt == 0) begin idle_st <= tgt; pend <= 1'b0; end
            else cnt <= cnt - 1;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic load_word(input logic [31:0] w);
        @(negedge clk); sw_word = w; sw_load = 1'b1;
        @(negedge clk); sw_load = 1'b0;
    endtask

    // Issue a request; return edges from request edge to done, check the write.
    task automatic run_op(input bit byp, input bit both, input bit poke,
                          input logic [31:0] exp_wr, output int n);
        int writes;
        @(negedge clk);
        byp_req = byp | both; lock_req = !byp | both;
        @(negedge clk);
        byp_req = 1'b0; lock_req = 1'b0;
        chk(wr_en === 1'b1, "R2/R4 write strobe", {31'd0, wr_en}, 32'd1);
        chk(wr_data === exp_wr, byp ? "R2 bypass data" : "R4 restore data", wr_data, exp_wr);
        writes = 0; n = 0;
        while (!done && n < 40) begin
            if (poke && n == 0) begin byp_req = 1'b1; lock_req = 1'b1; end
            @(negedge clk);
            byp_req = 1'b0; lock_req = 1'b0;
            n++;
            if (wr_en) writes++;
        end
        chk(writes == 0, "R8 no write while busy", writes, 0);
        @(negedge clk);
        chk(!done && !busy && !wr_en, "R7 done single pulse", {29'd0, done, busy, wr_en}, 0);
    endtask

    initial begin
        int n;
        logic [31:0] w;
        int exp_n;
        // R1: reset state
        repeat (3) @(negedge clk);
        chk(!busy && !done && !wr_en, "R1 reset outputs", {29'd0, busy, done, wr_en}, 0);
        rst_n = 1'b1;
        run_op(1'b0, 1'b0, 1'b0, 32'd0, n);
        chk(n == 0, "R1 relock after reset immediate", n, 0);

        // R9: divider field sweep
        for (int i = 0; i < 16; i++) begin
            clksel = 32'h1357_9BDF * (i + 1) ^ (i << 28);
            #1;
            chk(post_div === clksel[7:0], "R9 post divider", {24'd0, post_div}, {24'd0, clksel[7:0]});
        end

        // R2..R8: all enable codes x delays
        for (int d = 0; d < 4; d++) begin
            for (int c = 0; c < 8; c++) begin
                dly = d;
                w = ((32'hA5C3_0F00 ^ (c * 32'h0101_0100) ^ (d << 20)) & 32'hFFFF_FFF8) | c;
                load_word(w);
                exp_n = (c == 7) ? d + 3 : 1;
                run_op(1'b1, 1'b0, (d > 0), {w[31:3], 3'b101}, n);
                chk(n == exp_n, "R3 bypass completion edge", n, exp_n);
                exp_n = (c == 7) ? d + 3 : 0;
                run_op(1'b0, 1'b0, (c == 7), w, n);
                chk(n == exp_n, (c == 7) ? "R5 lock wait edge" : "R6 immediate done", n, exp_n);
            end
        end

        // R10: both requests at once take bypass
        dly = 1;
        w = 32'h0F0F_F0F7;
        load_word(w);
        run_op(1'b1, 1'b1, 1'b0, {w[31:3], 3'b101}, n);
        chk(n == 4, "R10 bypass wins tie", n, 4);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #2000000;
        fails++;
        tests++;
        $display("FAIL watchdog expired actual=hung expected=finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule